// File: doc/BRIEF.md
# Dual-Buffer Frame Transmit Controller

This block is a memory-mapped transmit engine with two 2 KB packet windows. Software fills one window with frame bytes through a 32-bit register port, sets a byte count, then writes a control word. The control word decides what the block does with the window. It either streams the stored bytes out of a byte-wide AXI4-Stream master, with tlast on the final byte, or takes the first six bytes of the window as the station MAC address.

Both windows share one streaming engine. A job started on one window while the other is being sent waits its turn, so frames never interleave on the stream. A completed job can raise a one-cycle interrupt pulse. Each window has its own enable for this, and one global enable sits over both. Preamble, FCS and the PHY side are handled downstream.

Top module: `tx_pingpong_ctrl`

## Requirements
- R1: After reset, irq and m_tvalid are 0, both control words and the global enable word read 0, and mac_addr equals the MAC_RESET parameter.
- R2: Register reads return data on reg_rdata one cycle after reg_rd. Window 0 spans byte addresses 0x000-0x7FF and window 1 spans 0x800-0xFFF. In each window, word offsets 0x000-0x7F0 hold frame data, 0x7F4 is the length, and 0x7FC is the control word. Address 0x7F8 is the global enable, and only its bit 31 is kept. All of these read back what was written.
- R3: A control write with bit 0 = 1 and bit 1 = 0 streams the window's bytes, using the count from its length register. Bytes go out most significant first within each data word, and word offset 0 comes first. tlast is asserted on the last byte only.
- R4: A control write with bit 0 = 1 and bit 1 = 1 emits no stream beat. It sets mac_addr to the first six bytes of that window, with byte 0 in bits 47:40.
- R5: Control bit 0 reads 1 while the window's job is pending or running. Bits 0 and 1 read 0 once the job completes. Bit 3 keeps its written value.
- R6: A control write with bit 0 = 1 to a window whose job is still running does not start a second frame.
- R7: On completion, irq pulses high for exactly one cycle, in the cycle after completion, if and only if that window's control bit 3 and global enable bit 31 are both set.
- R8: A job started on one window while the other is sending is held back until the current frame has ended, and then it is sent whole. When both windows are waiting, window 0 is served first.
- R9: A length of 0 completes the job with no beat. Control bit 0 clears and irq follows R7.
- R10: A length above 2036 is treated as 2036 bytes.
- R11: While m_tvalid is high and m_tready is low, m_tdata, m_tlast and m_tvalid hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address (bits 1:0 ignored) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| m_tdata | output | 8 | Stream byte |
| m_tvalid | output | 1 | Stream valid |
| m_tready | input | 1 | Stream ready |
| m_tlast | output | 1 | Final byte of a frame |
| irq | output | 1 | Completion interrupt pulse |
| mac_addr | output | 48 | Station MAC address |

## Verification
If the engine picks up the wrong window or data word, the fault shows on m_tdata at the first beat after the engine leaves idle, as a byte that does not match the bench's own copy of the window. A wrong length counter shows as a missing or extra tlast, or as a wrong beat count, by the end of that frame. A status bit that fails to clear shows when control bit 0 stays high on a read. A status bit that clears too early shows as a lost queued frame or as a second frame. A wrong interrupt gate shows in the cycle after completion, as an irq pulse that should not be there or one that is missing.

// File: rtl/tx_ppc_pkg.sv
package tx_ppc_pkg;
  localparam int CTRL_S_BIT = 0;
  localparam int CTRL_P_BIT = 1;
  localparam int CTRL_I_BIT = 3;
  localparam int GIE_BIT    = 31;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_MAC_HI} eng_state_e;

  // Effective byte count: requested length limited to the data area.
  function automatic logic [31:0] clamp_len(input logic [31:0] req, input logic [31:0] cap);
    return (req > cap) ? cap : req;
  endfunction

  // Byte of a stored word for a given lane; lane 0 is the most significant byte.
  function automatic logic [7:0] frame_byte(input logic [31:0] word, input logic [1:0] lane);
    logic [31:0] sh;
    sh = word << (8 * lane);
    return sh[31:24];
  endfunction
endpackage

// File: rtl/tx_ppc_ram.sv
module tx_ppc_ram #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] host_rdata,
  input  logic [AW-1:0] eng_addr,
  output logic [DW-1:0] eng_rdata
);
  logic [DW-1:0] mem [0:(1<<AW)-1];

  always_ff @(posedge clk) begin
    if (we) mem[host_addr] <= wdata;
  end

  assign host_rdata = mem[host_addr];
  assign eng_rdata  = mem[eng_addr];
endmodule

// File: rtl/tx_ppc_regs.sv
module tx_ppc_regs
  import tx_ppc_pkg::*;
#(
  parameter int WIN_AW = 11,
  parameter int LEN_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic                    reg_rd,
  input  logic [WIN_AW:2]         reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  output logic                    ram_we,
  output logic [WIN_AW-2:0]       ram_addr,
  input  logic [31:0]             ram_rdata,
  input  logic                    op_done,
  input  logic                    op_buf,
  output logic [1:0]              ctrl_s,
  output logic [1:0]              ctrl_p,
  output logic [1:0]              ctrl_i,
  output logic [1:0][LEN_W-1:0]   len_q,
  output logic                    gie_en,
  output logic                    irq
);
  localparam logic [WIN_AW-3:0] IDX_CTRL = {(WIN_AW-2){1'b1}};
  localparam logic [WIN_AW-3:0] IDX_GIE  = {{(WIN_AW-3){1'b1}}, 1'b0};
  localparam logic [WIN_AW-3:0] IDX_LEN  = {{(WIN_AW-4){1'b1}}, 2'b01};

  logic             sel;
  logic [WIN_AW-3:0] widx;
  logic is_data, is_len, is_gie, is_ctrl;

  assign sel     = reg_addr[WIN_AW];
  assign widx    = reg_addr[WIN_AW-1:2];
  assign is_data = (widx < IDX_LEN);
  assign is_len  = (widx == IDX_LEN);
  assign is_gie  = (widx == IDX_GIE);
  assign is_ctrl = (widx == IDX_CTRL);

  assign ram_we   = reg_wr & is_data;
  assign ram_addr = {sel, widx};

  // Per-window completion and host control-write events.
  logic [1:0] done_hit, host_ctrl, host_len, busy_eff;
  for (genvar b = 0; b < 2; b++) begin : g_win
    assign done_hit[b]  = op_done && (op_buf == 1'(b));
    assign host_ctrl[b] = reg_wr && is_ctrl && (sel == 1'(b));
    assign host_len[b]  = reg_wr && is_len && (sel == 1'(b));
    assign busy_eff[b]  = ctrl_s[b] && !done_hit[b];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrl_s[b] <= 1'b0;
        ctrl_p[b] <= 1'b0;
        ctrl_i[b] <= 1'b0;
        len_q[b]  <= '0;
      end else begin
        if (done_hit[b]) begin
          ctrl_s[b] <= 1'b0;
          ctrl_p[b] <= 1'b0;
        end
        if (host_ctrl[b]) begin
          ctrl_i[b] <= reg_wdata[CTRL_I_BIT];
          if (!busy_eff[b]) begin
            ctrl_s[b] <= reg_wdata[CTRL_S_BIT];
            ctrl_p[b] <= reg_wdata[CTRL_S_BIT] & reg_wdata[CTRL_P_BIT];
          end
        end
        if (host_len[b]) len_q[b] <= reg_wdata[LEN_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_en <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (reg_wr && is_gie && !sel) gie_en <= reg_wdata[GIE_BIT];
      irq <= op_done && ctrl_i[op_buf] && gie_en;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      if (is_data)       reg_rdata <= ram_rdata;
      else if (is_len)   reg_rdata <= 32'(len_q[sel]);
      else if (is_ctrl)  reg_rdata <= {28'b0, ctrl_i[sel], 1'b0, ctrl_p[sel], ctrl_s[sel]};
      else if (!sel)     reg_rdata <= {gie_en, 31'b0};
      else               reg_rdata <= '0;
    end
  end
endmodule

// File: rtl/tx_ppc_engine.sv
module tx_ppc_engine
  import tx_ppc_pkg::*;
#(
  parameter int          WIN_AW    = 11,
  parameter int          LEN_W     = 16,
  parameter logic [47:0] MAC_RESET = 48'h02_00_00_00_00_01
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            ctrl_s,
  input  logic [1:0]            ctrl_p,
  input  logic [1:0][LEN_W-1:0] len_q,
  output logic [WIN_AW-2:0]     rd_addr,
  input  logic [31:0]           rd_data,
  output logic [7:0]            m_tdata,
  output logic                  m_tvalid,
  input  logic                  m_tready,
  output logic                  m_tlast,
  output logic [47:0]           mac_addr,
  output logic                  op_done,
  output logic                  op_buf,
  output logic                  cur_buf,
  output logic                  mac_load
);
  localparam int MAX_LEN = ((1 << (WIN_AW-2)) - 3) * 4;

  eng_state_e        state;
  logic [WIN_AW-1:0] idx, last_idx;
  logic [31:0]       mac_hold;
  logic              pick_buf, pick_any;
  logic [31:0]       plen;

  // Fixed priority: window 0 first.
  assign pick_buf = !ctrl_s[0];
  assign pick_any = |ctrl_s;
  assign plen     = clamp_len(32'(len_q[pick_buf]), 32'(MAX_LEN));

  always_comb begin
    op_done  = 1'b0;
    op_buf   = cur_buf;
    mac_load = 1'b0;
    m_tvalid = 1'b0;
    m_tdata  = 8'h00;
    m_tlast  = 1'b0;
    rd_addr  = {pick_buf, {(WIN_AW-2){1'b0}}};
    unique case (state)
      ST_IDLE: begin
        op_buf = pick_buf;
        if (pick_any && !ctrl_p[pick_buf] && (plen == 32'd0)) op_done = 1'b1;
      end
      ST_SEND: begin
        rd_addr  = {cur_buf, idx[WIN_AW-1:2]};
        m_tvalid = 1'b1;
        m_tdata  = frame_byte(rd_data, idx[1:0]);
        m_tlast  = (idx == last_idx);
        op_done  = m_tready && m_tlast;
      end
      ST_MAC_HI: begin
        rd_addr  = {cur_buf, {(WIN_AW-3){1'b0}}, 1'b1};
        op_done  = 1'b1;
        mac_load = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_buf  <= 1'b0;
      idx      <= '0;
      last_idx <= '0;
      mac_hold <= '0;
      mac_addr <= MAC_RESET;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (pick_any) begin
            cur_buf <= pick_buf;
            if (ctrl_p[pick_buf]) begin
              mac_hold <= rd_data;
              state    <= ST_MAC_HI;
            end else if (plen != 32'd0) begin
              idx      <= '0;
              last_idx <= plen[WIN_AW-1:0] - 1'b1;
              state    <= ST_SEND;
            end
          end
        end
        ST_SEND: begin
          if (m_tready) begin
            if (m_tlast) state <= ST_IDLE;
            else         idx   <= idx + 1'b1;
          end
        end
        ST_MAC_HI: begin
          mac_addr <= {mac_hold, rd_data[31:16]};
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_pingpong_ctrl.sv
module tx_pingpong_ctrl #(
  parameter int          WIN_AW    = 11,
  parameter int          LEN_W     = 16,
  parameter logic [47:0] MAC_RESET = 48'h02_00_00_00_00_01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [WIN_AW:0]   reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [7:0]        m_tdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              m_tlast,
  output logic              irq,
  output logic [47:0]       mac_addr
);
  logic                  ram_we;
  logic [WIN_AW-2:0]     host_addr, eng_addr;
  logic [31:0]           host_rdata, eng_rdata;
  logic [1:0]            ctrl_s, ctrl_p, ctrl_i;
  logic [1:0][LEN_W-1:0] len_q;
  logic                  gie_en;
  logic                  op_done, op_buf, cur_buf, mac_load;
  logic                  unused_lsb;

  assign unused_lsb = ^reg_addr[1:0];

  tx_ppc_ram #(.AW(WIN_AW-1), .DW(32)) u_ram (
    .clk(clk), .we(ram_we), .host_addr(host_addr), .wdata(reg_wdata),
    .host_rdata(host_rdata), .eng_addr(eng_addr), .eng_rdata(eng_rdata)
  );

  tx_ppc_regs #(.WIN_AW(WIN_AW), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr[WIN_AW:2]), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ram_we(ram_we), .ram_addr(host_addr), .ram_rdata(host_rdata),
    .op_done(op_done), .op_buf(op_buf), .ctrl_s(ctrl_s), .ctrl_p(ctrl_p),
    .ctrl_i(ctrl_i), .len_q(len_q), .gie_en(gie_en), .irq(irq)
  );

  tx_ppc_engine #(.WIN_AW(WIN_AW), .LEN_W(LEN_W), .MAC_RESET(MAC_RESET)) u_eng (
    .clk(clk), .rst_n(rst_n), .ctrl_s(ctrl_s), .ctrl_p(ctrl_p), .len_q(len_q),
    .rd_addr(eng_addr), .rd_data(eng_rdata), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
    .m_tready(m_tready), .m_tlast(m_tlast), .mac_addr(mac_addr), .op_done(op_done),
    .op_buf(op_buf), .cur_buf(cur_buf), .mac_load(mac_load)
  );
endmodule

// File: rtl/tx_ppc_checker.sv
module tx_ppc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        m_tvalid,
  input logic        m_tready,
  input logic [7:0]  m_tdata,
  input logic        m_tlast,
  input logic        irq,
  input logic [47:0] mac_addr,
  input logic        op_done,
  input logic        cur_buf,
  input logic        mac_load,
  input logic [1:0]  ctrl_s,
  input logic        gie_en
);
  AST_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(op_done)) else $error("irq without completion"); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !gie_en) |=> !irq) else $error("irq while disabled"); // R7
  AST_BEAT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> ctrl_s[cur_buf]) else $error("beat with status clear"); // R5
  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)))
    else $error("stream changed under backpressure"); // R11
  AST_TLAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    m_tlast |-> m_tvalid) else $error("tlast without valid"); // R3
  AST_MAC_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mac_addr) |-> $past(mac_load)) else $error("mac changed outside load"); // R4
  AST_MAC_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    mac_load |-> !m_tvalid) else $error("beat during address load"); // R4
endmodule

bind tx_pingpong_ctrl tx_ppc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .m_tvalid(m_tvalid), .m_tready(m_tready),
  .m_tdata(m_tdata), .m_tlast(m_tlast), .irq(irq), .mac_addr(mac_addr),
  .op_done(op_done), .cur_buf(cur_buf), .mac_load(mac_load),
  .ctrl_s(ctrl_s), .gie_en(gie_en)
);

// File: tb/tx_pingpong_ctrl_test.sv
`timescale 1ns/1ps
module tx_pingpong_ctrl_test;
  localparam int          MAXLEN  = 2036;
  localparam logic [47:0] MAC_RST = 48'h02_00_00_00_00_01;

  logic        clk = 1'b0;
  logic        rst_n, reg_wr, reg_rd;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [7:0]  m_tdata;
  logic        m_tvalid, m_tready, m_tlast, irq;
  logic [47:0] mac_addr;

  always #4 clk = ~clk;

  tx_pingpong_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
    .m_tready(m_tready), .m_tlast(m_tlast), .irq(irq), .mac_addr(mac_addr)
  );

  int tests = 0, fails = 0;
  logic [31:0] bm [0:1][0:508];
  logic [7:0]  cap [0:4095];
  int cap_n = 0, last_cnt = 0, last_pos = -1, irq_cnt = 0, hold_bad = 0;
  int bp_pct = 100;
  bit gie_on = 0;
  logic [7:0] prev_data = 0;
  logic prev_last = 0, prev_stall = 0;

  // Stream monitor and ready driver, away from the active edge.
  always @(negedge clk) begin
    if (prev_stall && !(m_tvalid && m_tdata == prev_data && m_tlast == prev_last)) hold_bad++;
    m_tready = (($urandom % 100) < bp_pct);
    if (m_tvalid && m_tready) begin
      if (cap_n < 4096) cap[cap_n] = m_tdata;
      if (m_tlast) begin last_cnt++; last_pos = cap_n; end
      cap_n++;
    end
    prev_stall = m_tvalid && !m_tready;
    prev_data  = m_tdata;
    prev_last  = m_tlast;
    if (irq) irq_cnt++;
  end

  function automatic logic [11:0] base(input int b);
    return (b != 0) ? 12'h800 : 12'h000;
  endfunction

  function automatic logic [7:0] exp_byte(input int b, input int k);
    logic [31:0] w;
    w = bm[b][k/4];
    return w[8*(3-(k%4)) +: 8];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic fill(input int b, input int nbytes);
    for (int w = 0; w < (nbytes + 3) / 4; w++) begin
      logic [31:0] v;
      v = $urandom();
      bm[b][w] = v;
      wr(base(b) + 12'(w * 4), v);
    end
  endtask

  task automatic clear_mon();
    cap_n = 0; last_cnt = 0; last_pos = -1; irq_cnt = 0; hold_bad = 0;
  endtask

  task automatic wait_idle(input int b);
    logic [31:0] d;
    int guard;
    guard = 0;
    rd(base(b) + 12'h7FC, d);
    while (d[0] && guard < 20000) begin
      rd(base(b) + 12'h7FC, d);
      guard++;
    end
  endtask

  task automatic check_bytes(input int b, input int off, input int n, input string req);
    int bad;
    bad = 0;
    for (int k = 0; k < n; k++) if (cap[off + k] !== exp_byte(b, k)) bad++;
    chk(bad == 0, req, "byte mismatches", bad, 0);
  endtask

  task automatic run_frame(input int b, input int len, input bit ib, input string req);
    logic [31:0] d;
    int n;
    n = (len > MAXLEN) ? MAXLEN : len;
    wr(base(b) + 12'h7F4, 32'(len));
    clear_mon();
    wr(base(b) + 12'h7FC, ib ? 32'h9 : 32'h1);
    wait_idle(b);
    repeat (3) @(negedge clk);
    chk(cap_n == n, req, "beat count", cap_n, n);
    check_bytes(b, 0, n, req);
    chk(last_cnt == ((n > 0) ? 1 : 0), "R3", "tlast count", last_cnt, (n > 0) ? 1 : 0);
    if (n > 0) chk(last_pos == n - 1, "R3", "tlast position", last_pos, n - 1);
    chk(irq_cnt == ((ib && gie_on) ? 1 : 0), "R7", "irq pulses", irq_cnt, (ib && gie_on) ? 1 : 0);
    chk(hold_bad == 0, "R11", "backpressure hold violations", hold_bad, 0);
    rd(base(b) + 12'h7FC, d);
    chk(d == {28'b0, ib, 3'b000}, "R5", "control after completion", d, {28'b0, ib, 3'b000});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_2024));
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(irq == 1'b0, "R1", "irq", irq, 0);
    chk(m_tvalid == 1'b0, "R1", "tvalid", m_tvalid, 0);
    chk(mac_addr == MAC_RST, "R1", "mac_addr", mac_addr, MAC_RST);
    rd(12'h7FC, d); chk(d == 0, "R1", "ctrl0", d, 0);
    rd(12'hFFC, d); chk(d == 0, "R1", "ctrl1", d, 0);
    rd(12'h7F8, d); chk(d == 0, "R1", "gie", d, 0);

    // R2: register and data readback
    wr(12'h014, 32'hCAFE_0123); rd(12'h014, d); chk(d == 32'hCAFE_0123, "R2", "buf0 word", d, 32'hCAFE_0123);
    wr(12'h990, 32'h1357_9BDF); rd(12'h990, d); chk(d == 32'h1357_9BDF, "R2", "buf1 word", d, 32'h1357_9BDF);
    wr(12'hFF4, 32'd321); rd(12'hFF4, d); chk(d == 321, "R2", "len1", d, 321);
    wr(12'h7F8, 32'hFFFF_FFFF); rd(12'h7F8, d); chk(d == 32'h8000_0000, "R2", "gie bit31 only", d, 32'h8000_0000);
    gie_on = 1;

    // R3, R7: basic frame with interrupt
    bp_pct = 100; fill(0, 13); run_frame(0, 13, 1, "R3");
    bp_pct = 50;  fill(1, 40); run_frame(1, 40, 1, "R3");

    // R5, R6: busy readback, second start ignored
    bp_pct = 0; fill(1, 8);
    wr(12'hFF4, 32'd8); clear_mon(); wr(12'hFFC, 32'h1);
    rd(12'hFFC, d); chk(d[0] == 1'b1, "R5", "S while busy", d[0], 1);
    wr(12'hFFC, 32'h1);
    bp_pct = 70; wait_idle(1); repeat (4) @(negedge clk);
    chk(cap_n == 8, "R6", "beats after double start", cap_n, 8);
    check_bytes(1, 0, 8, "R6");

    // R8: queued start on the other window
    bp_pct = 0; fill(1, 10); fill(0, 7);
    wr(12'hFF4, 32'd10); wr(12'h7F4, 32'd7); clear_mon();
    wr(12'hFFC, 32'h1); wr(12'h7FC, 32'h1);
    bp_pct = 60; wait_idle(1); wait_idle(0); repeat (4) @(negedge clk);
    chk(cap_n == 17, "R8", "total beats", cap_n, 17);
    check_bytes(1, 0, 10, "R8");
    check_bytes(0, 10, 7, "R8");
    chk(last_cnt == 2, "R8", "tlast count", last_cnt, 2);

    // R4: address load
    bp_pct = 100;
    wr(12'h800, 32'hA1B2_C3D4); wr(12'h804, 32'hE5F6_0708); clear_mon();
    wr(12'hFFC, 32'hB); wait_idle(1); repeat (3) @(negedge clk);
    chk(mac_addr == 48'hA1B2_C3D4_E5F6, "R4", "mac_addr", mac_addr, 48'hA1B2_C3D4_E5F6);
    chk(cap_n == 0, "R4", "beats during load", cap_n, 0);
    chk(irq_cnt == 1, "R7", "irq after load", irq_cnt, 1);
    rd(12'hFFC, d); chk(d == 32'h8, "R5", "S,P cleared, I kept", d, 32'h8);

    // R7: gating
    fill(0, 5); run_frame(0, 5, 0, "R7");
    wr(12'h7F8, 32'h0); gie_on = 0; run_frame(0, 5, 1, "R7");
    wr(12'h7F8, 32'h8000_0000); gie_on = 1;

    // R9: zero length
    run_frame(1, 0, 1, "R9");

    // R10: clamp
    bp_pct = 90; fill(0, MAXLEN); run_frame(0, 3000, 1, "R10");

    // Random frames
    for (int it = 0; it < 16; it++) begin
      int b, len;
      b = $urandom % 2;
      len = 1 + ($urandom % 300);
      bp_pct = 30 + ($urandom % 71);
      fill(b, len);
      run_frame(b, len, 1'($urandom % 2), "R3");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule